// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from peripherals and presents them to a primary interrupt controller. Each line has an arm bit; a line that is asserted and armed is "live". Live lines are normally merged into a single cascade request. That request is driven on the primary input that has the cascade position (31 by default), so the primary controller sees one shared source for the whole group.

A per-line bypass mask lets software take chosen lines off the cascade. A bypassed live line is driven on the primary input with its own index, so it can be prioritised there on its own. The cascade position cannot be bypassed, because its primary input is the cascade request itself. Line 31 therefore always reaches the primary through the cascade.

Software reaches the block through a word-addressed register port with address, write data, a write strobe and read data. Arming is changed through a set port and a clear port, so that one line can be armed or disarmed without a read-modify-write. Software initialises the block by writing all ones to the clear port. All outputs are registered and change one clock after the input or write that causes them.

Top module: `cascade_intc`

## Requirements
- R1: After synchronous reset every arm bit and every bypass bit is 0, `prim_irq` is 0 and `bus_rdata` is 0.
- R2: A write to address 1 (arm-set) sets each arm bit whose data bit is 1 and leaves the others unchanged. Reading address 1 or address 2 returns the arm mask.
- R3: A write to address 2 (arm-clear) clears each arm bit whose data bit is 1 and leaves the others unchanged. Writing all ones disarms every line.
- R4: Reading address 0 returns the live lines, `src_lvl & arm`, with bit i for line i. A zero read means nothing is pending.
- R5: `prim_irq[31]` (the cascade position) is the OR over all lines of `src_lvl & arm & ~bypass`, registered one cycle.
- R6: For each i other than 31, `prim_irq[i]` is `src_lvl[i] & arm[i] & bypass[i]`, registered one cycle.
- R7: Address 3 holds the bypass mask and is written and read in full. Bit 31 always reads 0 and cannot be set, so line 31 always goes through the cascade.
- R8: Lines are level-sensitive and nothing is latched. When a line drops, its contribution to `prim_irq` disappears one cycle later. A line held high keeps its output high.
- R9: Writes to address 0 and to addresses 4 and above change no state. Reads of addresses 4 and above return 0.
- R10: Read data is registered from the state before any write in the same cycle. Outputs also use the mask in force before that edge, so a write takes effect on `prim_irq` and `bus_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Level interrupt lines from peripherals |
| bus_addr | input | 4 | Word address of the register port |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| prim_irq | output | 32 | Primary inputs: cascade request at bit 31, bypassed lines at their own index |

## Verification
The hardest case to reach is a write that changes the arm or bypass mask in the same cycle as a read or an output update. There the old mask must still be seen for one cycle. A directed read-during-write step covers this. A long random phase also issues writes to every address on most cycles while the source lines toggle, so mask changes and level changes often land on the same edge. A reference model compares `prim_irq` and `bus_rdata` on every clock. Directed steps also route line 31 to bypass and route every live line away from the cascade, to show that the cascade output falls when nothing is left on it.

// File: rtl/cascade_intc_pkg.sv
package cascade_intc_pkg;

  // Register selector decoded from the low two address bits.
  typedef enum logic [1:0] {
    SEL_PEND   = 2'd0,  // live lines, read only
    SEL_ARM    = 2'd1,  // write ones to arm
    SEL_DISARM = 2'd2,  // write ones to disarm
    SEL_BYPASS = 2'd3   // bypass mask, read/write
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;

endpackage

// File: rtl/cascade_intc_regs.sv
module cascade_intc_regs #(
  parameter int N_SRC    = 32,
  parameter int CASC_POS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_arm,
  input  logic             wr_disarm,
  input  logic             wr_bypass,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] arm_q,
  output logic [N_SRC-1:0] bypass_q
);

  localparam logic [N_SRC-1:0] BYPASS_WMASK = ~({{(N_SRC-1){1'b0}}, 1'b1} << CASC_POS);

  // Arm mask: set and clear ports never strobe together (one address).
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= '0;
    end else if (wr_arm) begin
      arm_q <= arm_q | wdata;
    end else if (wr_disarm) begin
      arm_q <= arm_q & ~wdata;
    end
  end

  // Bypass mask: cascade position is forced to stay on the cascade.
  always_ff @(posedge clk) begin
    if (rst) begin
      bypass_q <= '0;
    end else if (wr_bypass) begin
      bypass_q <= wdata & BYPASS_WMASK;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (arm_q == '0 && bypass_q == '0));

  assert_arm_sets_R2: assert property (@(posedge clk) disable iff (rst)
    wr_arm |=> ((arm_q & $past(wdata)) == $past(wdata)));

  assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wr_disarm |=> ((arm_q & $past(wdata)) == '0));

  assert_bypass_cascade_bit_R7: assert property (@(posedge clk) disable iff (rst)
    wr_bypass |=> (bypass_q[CASC_POS] == 1'b0));

endmodule

// File: rtl/cascade_intc_route.sv
module cascade_intc_route #(
  parameter int N_SRC    = 32,
  parameter int CASC_POS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] live,
  input  logic [N_SRC-1:0] bypass_q,
  output logic [N_SRC-1:0] prim_q
);

  localparam logic [N_SRC-1:0] CASC_BIT = {{(N_SRC-1){1'b0}}, 1'b1} << CASC_POS;

  logic [N_SRC-1:0] prim_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_line
      if (gi == CASC_POS) begin : g_casc
        // Shared request: every live line not taken off the cascade.
        assign prim_d[gi] = |(live & ~bypass_q);
      end else begin : g_direct
        assign prim_d[gi] = live[gi] & bypass_q[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
    end else begin
      prim_q <= prim_d;
    end
  end

  assert_cascade_needs_live_R5: assert property (@(posedge clk) disable iff (rst)
    prim_q[CASC_POS] |-> $past(live != '0));

  assert_direct_needs_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    ((prim_q & ~CASC_BIT & ~$past(bypass_q)) == '0));

  assert_quiet_follows_R8: assert property (@(posedge clk) disable iff (rst)
    $past(live == '0) |-> (prim_q == '0));

endmodule

// File: rtl/cascade_intc_rdmux.sv
module cascade_intc_rdmux
  import cascade_intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_dec_t         dec,
  input  logic [N_SRC-1:0] live,
  input  logic [N_SRC-1:0] arm_q,
  input  logic [N_SRC-1:0] bypass_q,
  output logic [N_SRC-1:0] rdata_q
);

  logic [N_SRC-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_PEND:   rdata_d = live;
        SEL_ARM:    rdata_d = arm_q;
        SEL_DISARM: rdata_d = arm_q;
        SEL_BYPASS: rdata_d = bypass_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assert_pend_within_arm_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(dec.hit) && $past(dec.sel) == SEL_PEND) |-> ((rdata_q & ~$past(arm_q)) == '0));

endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cascade_intc_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int ADDR_W   = 4,
  parameter int CASC_POS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic [N_SRC-1:0]  prim_irq
);

  localparam int SEL_W = 2;

  reg_dec_t         dec;
  logic [N_SRC-1:0] arm_q;
  logic [N_SRC-1:0] bypass_q;
  logic [N_SRC-1:0] live;
  logic             wr_arm, wr_disarm, wr_bypass;

  // Only the first four word addresses are mapped.
  always_comb begin
    dec.hit = (bus_addr[ADDR_W-1:SEL_W] == '0);
    dec.sel = reg_sel_e'(bus_addr[SEL_W-1:0]);
  end

  assign wr_arm    = bus_we && dec.hit && (dec.sel == SEL_ARM);
  assign wr_disarm = bus_we && dec.hit && (dec.sel == SEL_DISARM);
  assign wr_bypass = bus_we && dec.hit && (dec.sel == SEL_BYPASS);
  assign live      = src_lvl & arm_q;

  cascade_intc_regs #(.N_SRC(N_SRC), .CASC_POS(CASC_POS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_arm    (wr_arm),
    .wr_disarm (wr_disarm),
    .wr_bypass (wr_bypass),
    .wdata     (bus_wdata),
    .arm_q     (arm_q),
    .bypass_q  (bypass_q)
  );

  cascade_intc_route #(.N_SRC(N_SRC), .CASC_POS(CASC_POS)) u_route (
    .clk      (clk),
    .rst      (rst),
    .live     (live),
    .bypass_q (bypass_q),
    .prim_q   (prim_irq)
  );

  cascade_intc_rdmux #(.N_SRC(N_SRC)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .dec      (dec),
    .live     (live),
    .arm_q    (arm_q),
    .bypass_q (bypass_q),
    .rdata_q  (bus_rdata)
  );

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (!dec.hit || dec.sel == SEL_PEND)) |=> ($stable(arm_q) && $stable(bypass_q)));

endmodule

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_lvl = '0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] prim_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  cascade_intc u_dut (
    .clk       (clk),
    .rst       (rst),
    .src_lvl   (src_lvl),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .prim_irq  (prim_irq)
  );

  // Behavioural reference model, advanced on every rising edge.
  bit [31:0] m_arm, m_byp, exp_prim, exp_rd;
  string     exp_rd_tag;

  always @(posedge clk) begin
    bit [31:0] lv, pr;
    if (rst) begin
      m_arm = 0; m_byp = 0; exp_prim = 0; exp_rd = 0; exp_rd_tag = "R1";
    end else begin
      lv = src_lvl & m_arm;
      pr = 0;
      for (int i = 0; i < 31; i++) begin
        if (lv[i] && m_byp[i]) pr[i] = 1'b1;
        if (lv[i] && !m_byp[i]) pr[31] = 1'b1;
      end
      if (lv[31]) pr[31] = 1'b1;
      exp_prim = pr;
      case (bus_addr)
        4'd0: begin exp_rd = lv;    exp_rd_tag = "R4"; end
        4'd1: begin exp_rd = m_arm; exp_rd_tag = "R2"; end
        4'd2: begin exp_rd = m_arm; exp_rd_tag = "R3"; end
        4'd3: begin exp_rd = m_byp; exp_rd_tag = "R7"; end
        default: begin exp_rd = 0;  exp_rd_tag = "R9"; end
      endcase
      if (bus_we) begin
        case (bus_addr)
          4'd1: m_arm = m_arm | bus_wdata;
          4'd2: m_arm = m_arm & ~bus_wdata;
          4'd3: m_byp = bus_wdata & 32'h7FFF_FFFF;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the edge.
  always @(posedge clk) begin
    #2;
    n_checks++;
    if (prim_irq !== exp_prim) begin
      n_fail++;
      $display("FAIL %s prim_irq actual=%h expected=%h",
               (prim_irq[31] !== exp_prim[31]) ? "R5" : "R6", prim_irq, exp_prim);
    end
    n_checks++;
    if (bus_rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s bus_rdata actual=%h expected=%h", exp_rd_tag, bus_rdata, exp_rd);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #3; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    src_lvl = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    chk("R1 prim after reset", prim_irq, 32'h0);
    rd(4'd1, v); chk("R1 arm after reset", v, 32'h0);
    rd(4'd3, v); chk("R1 bypass after reset", v, 32'h0);

    @(negedge clk); src_lvl = 32'h0;
    wr(4'd1, 32'h0000_00F0);
    rd(4'd1, v); chk("R2 arm set", v, 32'h0000_00F0);
    wr(4'd1, 32'h0000_0F00);
    rd(4'd1, v); chk("R2 zeros keep bits", v, 32'h0000_0FF0);

    wr(4'd2, 32'h0000_0030);
    rd(4'd1, v); chk("R3 disarm", v, 32'h0000_0FC0);
    rd(4'd2, v); chk("R3 read at clear addr", v, 32'h0000_0FC0);

    @(negedge clk); src_lvl = 32'h0000_0A5A;
    rd(4'd0, v); chk("R4 pending masked", v, 32'h0000_0A40);
    settle(); chk("R5 cascade set", prim_irq, 32'h8000_0000);

    wr(4'd3, 32'h0000_0040);
    rd(4'd3, v); chk("R7 bypass readback", v, 32'h0000_0040);
    settle(); chk("R6 one direct plus cascade", prim_irq, 32'h8000_0040);
    wr(4'd3, 32'h0000_0A40);
    settle(); settle(); chk("R6 all direct cascade low", prim_irq, 32'h0000_0A40);

    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R7 cascade bit not settable", v, 32'h7FFF_FFFF);
    wr(4'd1, 32'h8000_0000);
    @(negedge clk); src_lvl = 32'h8000_0000;
    settle(); chk("R7 line 31 via cascade", prim_irq, 32'h8000_0000);

    @(negedge clk); src_lvl = 32'h0;
    settle(); chk("R8 drop follows", prim_irq, 32'h0);
    @(negedge clk); src_lvl = 32'h8000_0000;
    settle(); settle(); settle(); chk("R8 held level", prim_irq, 32'h8000_0000);

    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R9 arm unchanged", v, 32'h8000_0FC0);
    rd(4'd3, v); chk("R9 bypass unchanged", v, 32'h7FFF_FFFF);
    rd(4'd9, v); chk("R9 unmapped reads zero", v, 32'h0);

    @(negedge clk); bus_addr = 4'd1; bus_wdata = 32'h1; bus_we = 1'b1;
    @(posedge clk); #3; chk("R10 read old value", bus_rdata, 32'h8000_0FC0);
    @(negedge clk); bus_we = 1'b0;
    @(posedge clk); #3; chk("R10 new value next cycle", bus_rdata, 32'h8000_0FC1);

    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R3 disarm all", v, 32'h0);
    settle(); chk("R3 outputs quiet", prim_irq, 32'h0);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      src_lvl   = $urandom;
      bus_addr  = 4'($urandom_range(0, 7));
      bus_wdata = $urandom;
      bus_we    = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk); bus_we = 1'b0;
    settle();
    finish_run();
  end

endmodule